// File: doc/BRIEF.md
# Deferred Condition-Flag Evaluator

This block turns a saved description of the most recent operation into condition flags and folds them into a status word. The description holds an operation class, an operand size, the two operands, the result and, for multiplies, the upper half of the product. A pipeline can record only this description when an instruction executes. It then strobes the evaluator when a later instruction actually needs the flags.

Each evaluation computes a fresh flag set from the class-specific rule. That set is merged into the held status word under a write mask supplied with the operation. The extend flag is always part of the mask. When the extend input is set, a zero flag can only be cleared and never newly set. A bit-test class updates the status directly from a selected bit of an operand. A "flags live" class leaves the status alone.

Top module: `ccflag_eval`

## Requirements
- R1: After synchronous reset the status output is zero. While `eval_en` is low the status holds its value whatever the other inputs do.
- R2: Flag positions in the status word are C=bit 0, V=bit 1, Z=bit 2, N=bit 3, X=bit 4 and R=bit 8. An evaluation stores (old AND NOT wmask) OR (flags AND wmask). Here wmask is `flag_mask` with bit 4 forced on, so status bits outside wmask keep their value.
- R3: Add-like classes (op code 1 and codes 9 to 15) follow one rule at the selected size. Size code 0 is byte (sign bit 7, zero test on bits 7:0), code 1 is half (bit 15, bits 15:0) and code 2 is word (bit 31, all bits). The rule: if the result sign is 1, N is set, V is set when both operand signs are 0, and C is set when both are 1. Otherwise Z is set for a zero result, V is set when both operand signs are 1, and C is set when either is 1. Size code 3 produces no flags.
- R4: Subtract (code 2) and compare (code 3) apply the R3 rule to the bitwise inverse of the source and then invert C. This includes size code 3, which then gives C alone.
- R5: Multiply-carry (code 7) applies the R3 rule at word size with no inversion and places the carry in R instead of C.
- R6: Move/logic/shift (code 4) at half or word size sets N from the result sign bit, or else sets Z for a zero result at that size. At byte size and size code 3 it uses the R3 rule.
- R7: Unsigned multiply (code 6) forms the 64-bit value {mul_hi, result}. It sets Z if that value is zero, else sets N from bit 63, and sets V when `mul_hi` is nonzero.
- R8: Signed multiply (code 5) sets Z and N the same way as R7. It sets V when `mul_hi` differs from 32 copies of the result's bit 31.
- R9: Every evaluating class except live clears X. When `x_in` is 1 and the computed Z is 1, Z is dropped from wmask, so Z can fall but cannot rise.
- R10: Bit test (code 8) selects bit k = `opnd_src` mod 32 of `opnd_dst`. It clears X, sets N to that bit, and sets Z when bits k..0 are all zero. It also clears V and C when `version` is below 32. All other status bits are kept and `flag_mask` is ignored.
- R11: Op code 0 ("flags live") leaves the status unchanged even when `eval_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_en | input | 1 | Evaluate strobe |
| op_class | input | 4 | Operation class code |
| size_code | input | 2 | Operand size code |
| opnd_src | input | 32 | Source operand (bit index for bit test) |
| opnd_dst | input | 32 | Destination operand |
| result | input | 32 | Operation result |
| mul_hi | input | 32 | Upper product word |
| flag_mask | input | 32 | Class write mask |
| x_in | input | 1 | Extend flag of the deferred operation |
| version | input | 8 | Core version number |
| status | output | 32 | Registered status word |

## Verification
Flag computation is combinational and feeds one register, so every result is due at the first rising edge on which `eval_en` is high. The bench drives a complete operation record on a falling edge and holds it across one rising edge. It compares `status` on the next falling edge against a bench model that carries the previous status forward. The strobe is then dropped. Hold checks confirm that the value does not move while inputs keep changing and the strobe stays low.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  localparam int unsigned FC = 0;
  localparam int unsigned FV = 1;
  localparam int unsigned FZ = 2;
  localparam int unsigned FN = 3;
  localparam int unsigned FX = 4;
  localparam int unsigned FR = 8;

  typedef enum logic [3:0] {
    OP_LIVE = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_CMP = 4'd3,
    OP_MOVE = 4'd4, OP_MULS = 4'd5, OP_MULU = 4'd6, OP_MCP = 4'd7,
    OP_BTST = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_NONE = 2'd3
  } sz_e;
endpackage

// File: rtl/ccf_arith.sv
module ccf_arith
  import ccf_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 32
) (
  input  logic [1:0]    sz,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  input  logic [DW-1:0] res,
  input  logic          invert,
  input  logic          carry_to_r,
  output logic [SW-1:0] flags
);
  logic [DW-1:0] s_eff;
  logic sm, dm, rm, zr, ok, cy;

  assign s_eff = invert ? ~src : src;

  // sign and zero taps chosen by size
  always_comb begin
    ok = 1'b1;
    sm = 1'b0; dm = 1'b0; rm = 1'b0; zr = 1'b0;
    case (sz_e'(sz))
      SZ_B: begin sm = s_eff[7];    dm = dst[7];    rm = res[7];    zr = (res[7:0] == 8'd0); end
      SZ_H: begin sm = s_eff[15];   dm = dst[15];   rm = res[15];   zr = (res[15:0] == 16'd0); end
      SZ_W: begin sm = s_eff[DW-1]; dm = dst[DW-1]; rm = res[DW-1]; zr = (res == '0); end
      default: ok = 1'b0;
    endcase
  end

  always_comb begin
    flags = '0;
    cy = 1'b0;
    if (ok) begin
      if (rm) begin
        flags[FN] = 1'b1;
        if (!sm && !dm)     flags[FV] = 1'b1;
        else if (sm && dm)  cy = 1'b1;
      end else begin
        flags[FZ] = zr;
        flags[FV] = sm & dm;
        cy = sm | dm;
      end
    end
    if (invert) cy = ~cy;
    if (carry_to_r) flags[FR] = cy;
    else            flags[FC] = cy;
  end
endmodule

// File: rtl/ccf_mul.sv
module ccf_mul
  import ccf_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 32
) (
  input  logic          signed_mode,
  input  logic [DW-1:0] res,
  input  logic [DW-1:0] hi,
  output logic [SW-1:0] flags
);
  localparam int PW = 2 * DW;
  logic [PW-1:0] full;
  assign full = {hi, res};

  always_comb begin
    flags = '0;
    if (full == '0) flags[FZ] = 1'b1;
    else            flags[FN] = full[PW-1];
    if (signed_mode) flags[FV] = (hi != {DW{res[DW-1]}});
    else             flags[FV] = (hi != '0);
  end
endmodule

// File: rtl/ccf_btst.sv
module ccf_btst
  import ccf_pkg::*;
#(
  parameter int DW      = 32,
  parameter int SW      = 32,
  parameter int VW      = 8,
  parameter int VER_LIM = 32
) (
  input  logic [SW-1:0] old_status,
  input  logic [DW-1:0] t0,
  input  logic [DW-1:0] t1,
  input  logic [VW-1:0] version,
  output logic [SW-1:0] new_status
);
  localparam int SELW = $clog2(DW);
  localparam logic [SELW-1:0] TOPBIT = SELW'(DW - 1);

  logic [SELW-1:0] sel;
  logic [SELW-1:0] shamt;
  logic [DW-1:0]   low_mask;

  assign sel      = t1[SELW-1:0];
  assign shamt    = TOPBIT - sel;
  assign low_mask = {DW{1'b1}} >> shamt;

  always_comb begin
    new_status     = old_status;
    new_status[FX] = 1'b0;
    new_status[FN] = t0[sel];
    new_status[FZ] = ((t0 & low_mask) == '0);
    if (version < VW'(VER_LIM)) begin
      new_status[FV] = 1'b0;
      new_status[FC] = 1'b0;
    end
  end
endmodule

// File: rtl/ccflag_eval.sv
module ccflag_eval
  import ccf_pkg::*;
#(
  parameter int DW      = 32,
  parameter int SW      = 32,
  parameter int VW      = 8,
  parameter int VER_LIM = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eval_en,
  input  logic [3:0]    op_class,
  input  logic [1:0]    size_code,
  input  logic [DW-1:0] opnd_src,
  input  logic [DW-1:0] opnd_dst,
  input  logic [DW-1:0] result,
  input  logic [DW-1:0] mul_hi,
  input  logic [SW-1:0] flag_mask,
  input  logic          x_in,
  input  logic [VW-1:0] version,
  output logic [SW-1:0] status
);
  op_e op;
  assign op = op_e'(op_class);

  logic is_sub;
  logic [SW-1:0] arith_f, mcp_f, mul_f, move_f, btst_s, flags, wmask, merged, nxt;

  assign is_sub = (op == OP_SUB) || (op == OP_CMP);

  ccf_arith #(.DW(DW), .SW(SW)) u_arith (
    .sz(size_code), .src(opnd_src), .dst(opnd_dst), .res(result),
    .invert(is_sub), .carry_to_r(1'b0), .flags(arith_f));

  ccf_arith #(.DW(DW), .SW(SW)) u_mcp (
    .sz(SZ_W), .src(opnd_src), .dst(opnd_dst), .res(result),
    .invert(1'b0), .carry_to_r(1'b1), .flags(mcp_f));

  ccf_mul #(.DW(DW), .SW(SW)) u_mul (
    .signed_mode(op == OP_MULS), .res(result), .hi(mul_hi), .flags(mul_f));

  ccf_btst #(.DW(DW), .SW(SW), .VW(VW), .VER_LIM(VER_LIM)) u_btst (
    .old_status(status), .t0(opnd_dst), .t1(opnd_src),
    .version(version), .new_status(btst_s));

  // move/logic/shift: sign-or-zero at half and word, general rule otherwise
  always_comb begin
    move_f = '0;
    case (sz_e'(size_code))
      SZ_H: begin
        if (result[15]) move_f[FN] = 1'b1;
        else            move_f[FZ] = (result[15:0] == 16'd0);
      end
      SZ_W: begin
        if (result[DW-1]) move_f[FN] = 1'b1;
        else              move_f[FZ] = (result == '0);
      end
      default: move_f = arith_f;
    endcase
  end

  always_comb begin
    case (op)
      OP_MOVE:          flags = move_f;
      OP_MULS, OP_MULU: flags = mul_f;
      OP_MCP:           flags = mcp_f;
      default:          flags = arith_f;
    endcase
  end

  always_comb begin
    wmask     = flag_mask;
    wmask[FX] = 1'b1;
    if (x_in && flags[FZ]) wmask[FZ] = 1'b0;
    merged = (status & ~wmask) | (flags & wmask);
    case (op)
      OP_LIVE: nxt = status;
      OP_BTST: nxt = btst_s;
      default: nxt = merged;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          status <= '0;
    else if (eval_en) status <= nxt;
  end

  // R1: no strobe, no change
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !eval_en |=> $stable(status));

  // R11: live class keeps status
  a_r11_live_hold: assert property (@(posedge clk) disable iff (rst)
    (eval_en && op_class == 4'd0) |=> $stable(status));

  // R9: evaluating classes clear X
  a_r9_x_cleared: assert property (@(posedge clk) disable iff (rst)
    (eval_en && op_class != 4'd0) |=> !status[FX]);

  // R9: with X in, Z cannot rise (bit test excluded)
  a_r9_sticky_z: assert property (@(posedge clk) disable iff (rst)
    (eval_en && x_in && op_class != 4'd8 && !status[FZ]) |=> !status[FZ]);

  // R7: unsigned multiply with nonzero upper word sets V when unmasked
  a_r7_mulu_v: assert property (@(posedge clk) disable iff (rst)
    (eval_en && op_class == 4'd6 && flag_mask[FV] && mul_hi != '0) |=> status[FV]);
endmodule

// File: tb/test_ccflag_eval.sv
`timescale 1ns/1ps
module test_ccflag_eval;
  logic        clk = 1'b0;
  logic        rst;
  logic        eval_en;
  logic [3:0]  op_class;
  logic [1:0]  size_code;
  logic [31:0] opnd_src, opnd_dst, result, mul_hi, flag_mask;
  logic        x_in;
  logic [7:0]  version;
  logic [31:0] status;

  int total = 0;
  int bad   = 0;
  logic [31:0] model_st;

  always #2 clk = ~clk;

  ccflag_eval i_ccflag_eval (
    .clk(clk), .rst(rst), .eval_en(eval_en), .op_class(op_class),
    .size_code(size_code), .opnd_src(opnd_src), .opnd_dst(opnd_dst),
    .result(result), .mul_hi(mul_hi), .flag_mask(flag_mask), .x_in(x_in),
    .version(version), .status(status));

  function automatic logic [31:0] gen_rule(input int sz, input logic [31:0] s,
      input logic [31:0] d, input logic [31:0] r, input bit inv, input bit use_r);
    logic [31:0] f;
    int w;
    logic sm, dm, rm, cy;
    f = 0; cy = 0;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : (sz == 2) ? 32 : 0;
    if (inv) s = ~s;
    if (w != 0) begin
      sm = s[w-1]; dm = d[w-1]; rm = r[w-1];
      if (rm) begin
        f[3] = 1;
        if (!sm && !dm) f[1] = 1;
        if (sm && dm) cy = 1;
      end else begin
        if ((r << (32 - w)) == 0) f[2] = 1;
        if (sm && dm) f[1] = 1;
        if (sm || dm) cy = 1;
      end
    end
    if (inv) cy = !cy;
    if (use_r) f[8] = cy; else f[0] = cy;
    return f;
  endfunction

  function automatic logic [31:0] ref_next(input logic [31:0] old, input int op,
      input int sz, input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
      input logic [31:0] h, input logic [31:0] m, input logic x, input logic [7:0] ver);
    logic [31:0] f, wm, o;
    logic [63:0] full;
    int k;
    if (op == 0) return old;
    if (op == 8) begin
      k = int'(s % 32);
      o = old;
      o[4] = 0;
      o[3] = d[k];
      o[2] = ((d << (31 - k)) == 0);
      if (ver < 32) begin o[1] = 0; o[0] = 0; end
      return o;
    end
    f = 0;
    case (op)
      2, 3: f = gen_rule(sz, s, d, r, 1, 0);
      7:    f = gen_rule(2, s, d, r, 0, 1);
      4: begin
        if (sz == 1 || sz == 2) begin
          k = (sz == 1) ? 16 : 32;
          if (r[k-1]) f[3] = 1;
          else if ((r << (32 - k)) == 0) f[2] = 1;
        end else f = gen_rule(sz, s, d, r, 0, 0);
      end
      5, 6: begin
        full = {h, r};
        if (full == 0) f[2] = 1; else f[3] = full[63];
        if (op == 6) f[1] = (h != 0);
        else f[1] = (h != (r[31] ? 32'hFFFF_FFFF : 32'h0));
      end
      default: f = gen_rule(sz, s, d, r, 0, 0);
    endcase
    wm = m | 32'h10;
    if (x && f[2]) wm[2] = 0;
    return (old & ~wm) | (f & wm);
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0: return "R11";
      2, 3: return "R4";
      4: return "R6";
      5: return "R8";
      6: return "R7";
      7: return "R5";
      8: return "R10";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    total++;
    if (status !== exp) begin
      bad++;
      $display("FAIL %s status=%08h expected=%08h", tag, status, exp);
    end
  endtask

  task automatic do_eval(input string tag, input int op, input int sz,
      input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
      input logic [31:0] h, input logic [31:0] m, input logic x, input logic [7:0] ver);
    logic [31:0] exp;
    exp = ref_next(model_st, op, sz, s, d, r, h, m, x, ver);
    op_class = 4'(op); size_code = 2'(sz);
    opnd_src = s; opnd_dst = d; result = r; mul_hi = h;
    flag_mask = m; x_in = x; version = ver; eval_en = 1'b1;
    @(negedge clk);
    eval_en = 1'b0;
    check(tag, exp);
    model_st = exp;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1 status=%08h expected=completion", status);
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst = 1'b1; eval_en = 1'b0; op_class = 0; size_code = 0;
    opnd_src = 0; opnd_dst = 0; result = 0; mul_hi = 0; flag_mask = 0;
    x_in = 0; version = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    model_st = 32'h0;
    check("R1", 32'h0);

    // R3 byte: both signs 1, zero low byte -> Z V C
    do_eval("R3", 1, 0, 32'h80, 32'h80, 32'h100, 0, 32'h10F, 0, 8'd40);
    check("R3", 32'h7);
    // R3 half: positive operands to negative result -> N V
    do_eval("R3", 1, 1, 32'h7FFF, 32'h1, 32'h8000, 0, 32'h10F, 0, 8'd40);
    check("R3", 32'hA);
    // R3 size code 3: no flags
    do_eval("R3", 1, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 0, 32'h10F, 0, 8'd40);
    check("R3", 32'h0);
    // R4 equal compare -> Z only
    do_eval("R4", 3, 2, 32'h1, 32'h1, 32'h0, 0, 32'h10F, 0, 8'd40);
    check("R4", 32'h4);
    // R4 size code 3 -> C alone
    do_eval("R4", 2, 3, 32'h0, 32'h0, 32'h5, 0, 32'h10F, 0, 8'd40);
    check("R4", 32'h1);
    // R5 multiply-carry -> Z V R
    do_eval("R5", 7, 0, 32'h8000_0000, 32'h8000_0000, 32'h0, 0, 32'h10F, 0, 8'd40);
    check("R5", 32'h106);
    // R2 partial mask: only C written, R kept
    do_eval("R2", 1, 2, 32'h8000_0000, 32'h8000_0000, 32'h0, 0, 32'h1, 0, 8'd40);
    check("R2", 32'h107);
    // R6 word move negative -> N
    do_eval("R6", 4, 2, 32'h0, 32'h0, 32'h8000_0000, 0, 32'h0F, 0, 8'd40);
    check("R6", 32'h108);
    // R7 upper word nonzero -> V
    do_eval("R7", 6, 2, 0, 0, 32'h0, 32'h1, 32'h0F, 0, 8'd40);
    check("R7", 32'h102);
    // R8 -1 sign extended -> N only
    do_eval("R8", 5, 2, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0F, 0, 8'd40);
    check("R8", 32'h108);
    // R9 sticky: Z 0 stays 0 when X in and new Z is 1
    do_eval("R9", 4, 2, 0, 0, 32'h0, 0, 32'h0F, 1, 8'd40);
    check("R9", 32'h100);
    // R10 bit 4 of 0x10 set, index 36 mod 32
    do_eval("R10", 8, 0, 32'd36, 32'h10, 0, 0, 32'h0, 0, 8'd40);
    check("R10", 32'h108);
    do_eval("R10", 8, 0, 32'd3, 32'h10, 0, 0, 32'h0, 0, 8'd10);
    check("R10", 32'h104);
    // R11 live
    do_eval("R11", 0, 2, 32'h1, 32'h2, 32'h3, 32'h4, 32'hFFFF_FFFF, 0, 8'd0);

    for (int i = 0; i < 1500; i++) begin
      int op, sz;
      logic [31:0] s, d, r, h, m;
      op = int'($urandom % 11);
      sz = int'($urandom % 4);
      s = $urandom; d = $urandom; r = $urandom; h = $urandom;
      case ($urandom % 6)
        0: r = 0;
        1: r = r & 32'hFFFF_FF00;
        2: r = r & 32'hFFFF_0000;
        default: ;
      endcase
      case ($urandom % 4)
        0: h = 0;
        1: h = r[31] ? 32'hFFFF_FFFF : 32'h0;
        default: ;
      endcase
      m = ($urandom % 3 == 0) ? 32'hFFFF_FFFF : ($urandom & 32'h1FF);
      if (op == 10) op = 9 + int'($urandom % 7);
      do_eval(tag_of(op), op, sz, s, d, r, h, m, 1'($urandom), 8'($urandom % 64));
      if (i % 100 == 0) begin
        // R1: strobe low, inputs move, status holds
        op_class = 4'd1; result = $urandom; flag_mask = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        check("R1", model_st);
      end
    end
    finish_run();
  end
endmodule